// File: doc/BRIEF.md
# Self-Starting Seven-State Sequence Counter

This block is a free-running 3-bit Moore counter that walks a fixed, irregular cycle of seven codes. It takes no data inputs: every rising clock edge moves it one step along the cycle. The count output is the state register itself, so no output decoding is needed. Bit 2 is the most significant bit.

Of the eight 3-bit codes, only one is not on the cycle. That code is sent back to the start of the cycle, so the counter rejoins the loop whatever value its flip-flops hold after power-up. A synchronous active-high reset forces the start code. Each next-state bit is built as a sum of products over the current-state bits. A parameter sets the power-up content of the state register, so that the recovery path can be exercised.

Top module: `seqcnt7`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 000 after that edge.
- R2: With `rst` low, each rising edge moves `count` along the cycle 000 → 010 → 111 → 100 → 110 → 011 → 001 → 000.
- R3: The unused code 101 is followed by 000 on the next rising edge.
- R4: With `rst` low, `count` changes at every rising edge. No code maps to itself.
- R5: `count` never shows 101 after any rising edge.
- R6: Once on the cycle with no reset in between, `count` repeats with a period of exactly seven edges.
- R7: From any of the eight power-up codes, `count` is on the cycle after one rising edge.
- R8: Reset takes priority over stepping, whatever the current code. After reset is released the cycle resumes with 010.
- R9: Before the first clock edge, `count` holds the value of the `POWERUP` parameter (default 000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads 000 |
| count | output | 3 | Current state of the counter, bit 2 most significant |

## Verification
The hard case is the recovery from 101. After any reset the counter never reaches that code, so normal stimulus on the ports cannot get there. The bench therefore builds eight extra copies of the counter, each with a different `POWERUP` value and no reset applied. This places every code, 101 included, in the register before the first edge. It then checks the first step out of each code and the seven-edge period that follows. A mid-run reset on the main instance shows that reset takes priority and that the counter restarts cleanly.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;

    localparam int CNT_W     = 3;
    localparam int NUM_CODES = 1 << CNT_W;
    localparam int LOOP_LEN  = 7;
    localparam int AGE_W     = 4;

    typedef logic [CNT_W-1:0]     code_t;
    typedef logic [NUM_CODES-1:0] onset_t;

    typedef struct packed {
        code_t cur;
        code_t nxt;
    } step_t;

    localparam code_t START_CODE = 3'b000;
    localparam code_t SPARE_CODE = 3'b101;

    // Position in the cycle -> code held there
    function automatic code_t loop_code(int pos);
        code_t c;
        case (pos)
            0:       c = 3'b000;
            1:       c = 3'b010;
            2:       c = 3'b111;
            3:       c = 3'b100;
            4:       c = 3'b110;
            5:       c = 3'b011;
            6:       c = 3'b001;
            default: c = START_CODE;
        endcase
        return c;
    endfunction

    // Successor of any code; codes off the cycle go to the start
    function automatic code_t successor(code_t c);
        code_t s;
        s = START_CODE;
        for (int p = 0; p < LOOP_LEN; p++) begin
            if (loop_code(p) == c) s = loop_code((p + 1) % LOOP_LEN);
        end
        return s;
    endfunction

    // Minterms of the current state for which next-state bit b is one
    function automatic onset_t minterm_mask(int b);
        onset_t m;
        code_t  s;
        m = '0;
        for (int k = 0; k < NUM_CODES; k++) begin
            s    = successor(code_t'(k));
            m[k] = s[b];
        end
        return m;
    endfunction

endpackage

// File: rtl/seqcnt_sop_bit.sv
module seqcnt_sop_bit
    import seqcnt_pkg::*;
#(
    parameter onset_t ONSET = '0
) (
    input  code_t cur,
    output logic  nxt_bit
);

    onset_t term;

    // One AND term per minterm in the on-set, ORed below
    for (genvar m = 0; m < NUM_CODES; m++) begin : g_term
        if (ONSET[m]) begin : g_on
            assign term[m] = (cur == code_t'(m));
        end else begin : g_off
            assign term[m] = 1'b0;
        end
    end

    assign nxt_bit = |term;

endmodule

// File: rtl/seqcnt_next.sv
module seqcnt_next
    import seqcnt_pkg::*;
(
    input  code_t cur,
    output code_t nxt
);

    for (genvar b = 0; b < CNT_W; b++) begin : g_bit
        seqcnt_sop_bit #(.ONSET(minterm_mask(b))) u_bit (
            .cur     (cur),
            .nxt_bit (nxt[b])
        );
    end

    // R5: next-state logic never produces the spare code
    always_comb begin
        assert_no_spare_next_R5: assert (nxt != SPARE_CODE);
    end

endmodule

// File: rtl/seqcnt_state.sv
module seqcnt_state
    import seqcnt_pkg::*;
#(
    parameter code_t POWERUP = START_CODE
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t d,
    output code_t q
);

    code_t q_r = POWERUP;

    always_ff @(posedge clk) begin
        if (rst) q_r <= START_CODE;
        else     q_r <= d;
    end

    assign q = q_r;

    assert_reset_loads_start_R1: assert property (@(posedge clk)
        rst |=> q == START_CODE);

    assert_always_moves_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> q != $past(q));

endmodule

// File: rtl/seqcnt7.sv
module seqcnt7
    import seqcnt_pkg::*;
#(
    parameter code_t POWERUP = START_CODE
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] count
);

    step_t step;

    seqcnt_next u_next (
        .cur (step.cur),
        .nxt (step.nxt)
    );

    seqcnt_state #(.POWERUP(POWERUP)) u_state (
        .clk (clk),
        .rst (rst),
        .d   (step.nxt),
        .q   (step.cur)
    );

    assign count = step.cur;

    // Edges since the last reset (or since power-up), saturating
    logic [AGE_W-1:0] age = '0;
    always_ff @(posedge clk) begin
        if (rst)                     age <= '0;
        else if (age != {AGE_W{1'b1}}) age <= age + 1'b1;
    end

    assert_step_from_start_R2: assert property (@(posedge clk) disable iff (rst)
        count == 3'b000 |=> count == 3'b010);

    assert_step_from_top_R2: assert property (@(posedge clk) disable iff (rst)
        count == 3'b111 |=> count == 3'b100);

    assert_step_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        count == 3'b001 |=> count == 3'b000);

    assert_spare_recovers_R3: assert property (@(posedge clk) disable iff (rst)
        count == SPARE_CODE |=> count == START_CODE);

    assert_in_loop_after_edge_R7: assert property (@(posedge clk) disable iff (rst)
        age != '0 |-> count != SPARE_CODE);

    assert_period_seven_R6: assert property (@(posedge clk) disable iff (rst)
        age >= AGE_W'(8) |-> count == $past(count, 7));

endmodule

// File: tb/seqcnt7_bench.sv
module seqcnt7_bench;

    localparam int PERIOD = 10;
    localparam int MAIN_CYCLES = 40;
    localparam int RESET_AT = 17;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pu_rst = 1'b0;
    logic [2:0] count;
    logic [2:0] pu_count [8];

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    seqcnt7 u_seqcnt7 (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    for (genvar k = 0; k < 8; k++) begin : g_pu
        seqcnt7 #(.POWERUP(3'(k))) u_seqcnt7_pu (
            .clk   (clk),
            .rst   (pu_rst),
            .count (pu_count[k])
        );
    end

    // Behavioural reference: the cycle as an ordered list
    logic [2:0] order [$] = '{3'b000, 3'b010, 3'b111, 3'b100, 3'b110, 3'b011, 3'b001};

    function automatic logic [2:0] ref_next(logic [2:0] c);
        for (int i = 0; i < order.size(); i++)
            if (order[i] == c) return order[(i + 1) % order.size()];
        return 3'b000;
    endfunction

    function automatic bit on_loop(logic [2:0] c);
        for (int i = 0; i < order.size(); i++)
            if (order[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: count=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: count=%b expected=finish", count);
        finish_run();
    end

    initial begin
        logic [2:0] exp;
        logic [2:0] hist [$];
        logic [2:0] first_step [8];

        // R9: power-up contents visible before any edge
        #1;
        for (int k = 0; k < 8; k++) check("R9", pu_count[k], 3'(k));
        check("R9", count, 3'b000);

        // First edge (rst high on main instance)
        @(negedge clk);
        check("R1", count, 3'b000);
        for (int k = 0; k < 8; k++) begin
            // R7 (and R3 for code 101): one edge lands on the cycle
            check(k == 5 ? "R3" : "R7", pu_count[k], ref_next(3'(k)));
            vectors++;
            if (!on_loop(pu_count[k])) begin
                miscompares++;
                $display("FAIL R7: count=%b expected=on-cycle code", pu_count[k]);
            end
            first_step[k] = pu_count[k];
        end

        rst = 1'b0;
        exp = 3'b000;
        hist.delete();
        hist.push_back(count);

        for (int cyc = 0; cyc < MAIN_CYCLES; cyc++) begin
            logic [2:0] prev;
            prev = count;
            rst = (cyc == RESET_AT);
            exp = rst ? 3'b000 : ref_next(exp);
            @(negedge clk);
            if (rst) begin
                check("R8", count, 3'b000);
                hist.delete();
            end else begin
                check("R2", count, exp);
                vectors++;
                if (count === prev) begin
                    miscompares++;
                    $display("FAIL R4: count=%b expected=change from %b", count, prev);
                end
                vectors++;
                if (count === 3'b101) begin
                    miscompares++;
                    $display("FAIL R5: count=%b expected=not 101", count);
                end
                if (cyc == RESET_AT + 1) check("R8", count, 3'b010);
            end
            hist.push_back(count);
            if (hist.size() > 7) check("R6", count, hist[hist.size() - 8]);
            // Power-up copies: period of seven after their first step
            if (cyc == 6)
                for (int k = 0; k < 8; k++) check("R6", pu_count[k], first_step[k]);
        end
        rst = 1'b0;
        finish_run();
    end

endmodule